// File: doc/BRIEF.md
# Page Entry Access Checker and Status Updater

This block sits beside a page-table walker. For each request it takes one 64-bit page table entry, the kind of access (read, write or instruction fetch) and the privilege level of the requester. It decides whether the access may proceed. If it may, the block returns the entry with its accessed and dirty status flags set as the access requires, and a write-back strobe that tells the walker to store the entry back to the table. If it may not, the block returns a fault cause code and leaves the entry untouched.

The status flags are sticky. The block only ever sets them, and only when they are not yet set. Clearing them is left to software through a separate write path that this block does not see. The result appears one clock after the request. A new request may be issued on every clock.

Top module: `pte_access_unit`

## Requirements
- R1: While reset is held, and on the first clock after it is released, respValid, respWriteBack and respFault are 0 and respEntry is all zeros.
- R2: Every result appears on the clock after its request. respValid copies reqValid from one clock earlier. After a clock with reqValid low, respWriteBack and respFault are 0.
- R3: An entry with bit 0 (present) equal to 0 gives fault code 1 for every access kind and privilege level. This fault outranks every other fault.
- R4: An entry that is present and has bit 2 (user allowed) equal to 0, accessed at privilege level 3, gives fault code 2. Privilege levels 0, 1 and 2 never get this fault.
- R5: A write (reqKind 1) to a present entry that the privilege check allows, with bit 1 (writable) equal to 0, gives fault code 3. Reads (reqKind 0 or 3) and fetches (reqKind 2) never get this fault.
- R6: An instruction fetch (reqKind 2) that passes the checks above, from an entry with bit 63 (no-execute) equal to 1, gives fault code 4. Fault code 0 means the access is allowed.
- R7: An allowed access of any kind returns the entry with bit 5 (accessed) set. An allowed write also sets bit 6 (dirty). Reads and fetches leave bit 6 as it was. No access ever clears bit 5 or bit 6.
- R8: respWriteBack is 1 only for an allowed access that changes bit 5 or bit 6. An allowed access to an entry that already has the flags it needs gives respWriteBack 0.
- R9: A faulting access returns the entry exactly as it was received, with respWriteBack 0.
- R10: All entry bits other than 5 and 6 pass through unchanged, including the software bits 9 to 11. This holds whatever the values of those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this clock |
| reqEntry | input | 64 | Page table entry under test |
| reqKind | input | 2 | 0 read, 1 write, 2 instruction fetch, 3 treated as read |
| reqPriv | input | 2 | Privilege level of the requester, 3 is least privileged |
| respValid | output | 1 | Result of the previous clock's request is present |
| respEntry | output | 64 | Entry after status update (unchanged on a fault) |
| respWriteBack | output | 1 | Entry changed and must be stored back |
| respFault | output | 3 | Fault cause, 0 when the access is allowed |

## Verification
Directed entries make exactly one permission bit fail at a time. This shows that each fault is detected and gets its own code. Further entries make two or more checks fail together, and these show the priority order. Separate sequences repeat reads and writes over entries with the flags already clear, already set, or partly set. These tell a first access (update plus write-back) apart from a repeat access (no write-back), and a read-style access (accessed only) apart from a write (accessed and dirty). A long random sweep over entry values, access kinds and privilege levels is compared every clock against a behavioural model. It catches mistakes in pass-through bits and in corner combinations that the directed cases miss.

// File: rtl/pte_pkg.sv
package pte_pkg;
  parameter int ENTRY_W   = 64;
  parameter int PRIV_W    = 2;
  parameter int USER_PRIV = 3;

  localparam int PRESENT_POS = 0;
  localparam int WRITE_POS   = 1;
  localparam int USER_POS    = 2;
  localparam int ACC_POS     = 5;
  localparam int DIRTY_POS   = 6;
  localparam int NOEXEC_POS  = ENTRY_W - 1;
  localparam int CAUSE_W     = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_SPARE = 2'd3
  } accKind_e;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_ABSENT = 3'd1,
    CAUSE_PRIV   = 3'd2,
    CAUSE_RDONLY = 3'd3,
    CAUSE_NOEXEC = 3'd4
  } faultCause_e;

  typedef struct packed {
    logic present;
    logic writable;
    logic userOk;
    logic noExec;
    logic accSet;
    logic dirtySet;
  } pteFlags_t;

  typedef struct packed {
    logic        take;
    logic        markAcc;
    logic        markDirty;
    faultCause_e cause;
  } pteStrobe_t;
endpackage

// File: rtl/pte_ctrl.sv
module pte_ctrl
  import pte_pkg::*;
(
  input  logic              reqValid,
  input  pteFlags_t         flags,
  input  accKind_e          kind,
  input  logic [PRIV_W-1:0] priv,
  output pteStrobe_t        strobe
);
  logic isWrite;
  logic isFetch;
  logic userLevel;
  faultCause_e cause;

  assign isWrite   = (kind == ACC_WRITE);
  assign isFetch   = (kind == ACC_FETCH);
  assign userLevel = (priv == PRIV_W'(USER_PRIV));

  // Fault priority: absent, privilege, read-only, no-execute
  always_comb begin
    if (!flags.present)
      cause = CAUSE_ABSENT;
    else if (userLevel && !flags.userOk)
      cause = CAUSE_PRIV;
    else if (isWrite && !flags.writable)
      cause = CAUSE_RDONLY;
    else if (isFetch && flags.noExec)
      cause = CAUSE_NOEXEC;
    else
      cause = CAUSE_NONE;
  end

  always_comb begin
    strobe.take      = reqValid;
    strobe.cause     = reqValid ? cause : CAUSE_NONE;
    strobe.markAcc   = reqValid && (cause == CAUSE_NONE) && !flags.accSet;
    strobe.markDirty = reqValid && (cause == CAUSE_NONE) && isWrite && !flags.dirtySet;
  end
endmodule

// File: rtl/pte_datapath.sv
module pte_datapath
  import pte_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ENTRY_W-1:0] reqEntry,
  input  pteStrobe_t         strobe,
  output pteFlags_t          flags,
  output logic               respValid,
  output logic [ENTRY_W-1:0] respEntry,
  output logic               respWriteBack,
  output logic [CAUSE_W-1:0] respFault
);
  logic [ENTRY_W-1:0] setMask;
  logic [ENTRY_W-1:0] nextEntry;

  assign flags.present  = reqEntry[PRESENT_POS];
  assign flags.writable = reqEntry[WRITE_POS];
  assign flags.userOk   = reqEntry[USER_POS];
  assign flags.noExec   = reqEntry[NOEXEC_POS];
  assign flags.accSet   = reqEntry[ACC_POS];
  assign flags.dirtySet = reqEntry[DIRTY_POS];

  always_comb begin
    setMask            = '0;
    setMask[ACC_POS]   = strobe.markAcc;
    setMask[DIRTY_POS] = strobe.markDirty;
  end

  assign nextEntry = reqEntry | setMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid     <= 1'b0;
      respEntry     <= '0;
      respWriteBack <= 1'b0;
      respFault     <= '0;
    end else begin
      respValid     <= strobe.take;
      respWriteBack <= strobe.markAcc | strobe.markDirty;
      respFault     <= strobe.cause;
      if (strobe.take)
        respEntry <= nextEntry;
    end
  end
endmodule

// File: rtl/pte_access_unit.sv
module pte_access_unit
  import pte_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ENTRY_W-1:0] reqEntry,
  input  logic [1:0]         reqKind,
  input  logic [PRIV_W-1:0]  reqPriv,
  output logic               respValid,
  output logic [ENTRY_W-1:0] respEntry,
  output logic               respWriteBack,
  output logic [CAUSE_W-1:0] respFault
);
  pteFlags_t  flags;
  pteStrobe_t strobe;

  pte_ctrl ctrl (
    .reqValid (reqValid),
    .flags    (flags),
    .kind     (accKind_e'(reqKind)),
    .priv     (reqPriv),
    .strobe   (strobe)
  );

  pte_datapath dp (
    .clk           (clk),
    .rstN          (rstN),
    .reqEntry      (reqEntry),
    .strobe        (strobe),
    .flags         (flags),
    .respValid     (respValid),
    .respEntry     (respEntry),
    .respWriteBack (respWriteBack),
    .respFault     (respFault)
  );
endmodule

// File: rtl/pte_access_chk.sv
module pte_access_chk
  import pte_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [ENTRY_W-1:0] reqEntry,
  input logic [1:0]         reqKind,
  input logic [PRIV_W-1:0]  reqPriv,
  input logic               respValid,
  input logic [ENTRY_W-1:0] respEntry,
  input logic               respWriteBack,
  input logic [CAUSE_W-1:0] respFault
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!respValid && !respWriteBack && respFault == '0));

  // R3
  absent_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqEntry[PRESENT_POS]) |=> (respFault == CAUSE_W'(1)));

  // R4
  priv_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqEntry[PRESENT_POS] && !reqEntry[USER_POS] &&
     reqPriv == PRIV_W'(USER_PRIV)) |=> (respFault == CAUSE_W'(2)));

  // R7
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> ((respEntry[ACC_POS] | !$past(reqEntry[ACC_POS])) &&
                  (respEntry[DIRTY_POS] | !$past(reqEntry[DIRTY_POS]))));

  // R8
  wb_changes_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (respWriteBack == (respEntry != $past(reqEntry))));

  // R9
  fault_untouched_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (respFault == '0 || (respEntry == $past(reqEntry) && !respWriteBack)));

  // R10
  avl_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (respEntry[11:9] == $past(reqEntry[11:9])));
endmodule

bind pte_access_unit pte_access_chk chk (.*);

// File: tb/pte_access_unit_test.sv
`timescale 1ns/1ps
module pte_access_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] reqEntry = '0;
  logic [1:0]  reqKind = '0;
  logic [1:0]  reqPriv = '0;
  logic        respValid;
  logic [63:0] respEntry;
  logic        respWriteBack;
  logic [2:0]  respFault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          valid;
    logic [63:0] entry;
    bit          wb;
    int          cause;
    logic [63:0] inEntry;
  } expect_t;

  expect_t pending[$];

  always #2 clk = ~clk;

  pte_access_unit uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEntry(reqEntry),
    .reqKind(reqKind), .reqPriv(reqPriv), .respValid(respValid),
    .respEntry(respEntry), .respWriteBack(respWriteBack), .respFault(respFault)
  );

  function automatic expect_t model(bit v, logic [63:0] e, int k, int p);
    expect_t x;
    x.valid = v;
    x.inEntry = e;
    x.entry = e;
    x.cause = 0;
    x.wb = 0;
    if (v) begin
      if (!e[0]) x.cause = 1;
      else if (p == 3 && !e[2]) x.cause = 2;
      else if (k == 1 && !e[1]) x.cause = 3;
      else if (k == 2 && e[63]) x.cause = 4;
      if (x.cause == 0) begin
        x.entry[5] = 1'b1;
        if (k == 1) x.entry[6] = 1'b1;
      end
      x.wb = (x.entry != e);
    end
    return x;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    expect_t x;
    string ftag;
    if (pending.size() == 0) return;
    x = pending.pop_front();
    check(respValid == x.valid, "R2", "respValid", 64'(respValid), 64'(x.valid));
    if (!x.valid) begin
      check(respWriteBack == 0 && respFault == 0, "R2", "idle wb/fault",
            {respWriteBack, respFault}, 64'd0);
      return;
    end
    case (x.cause)
      1: ftag = "R3";
      2: ftag = "R4";
      3: ftag = "R5";
      4: ftag = "R6";
      default: ftag = "R6";
    endcase
    check(int'(respFault) == x.cause, ftag, "respFault", 64'(respFault), 64'(x.cause));
    check(respEntry == x.entry, (x.cause != 0) ? "R9" : "R7", "respEntry", respEntry, x.entry);
    check(respWriteBack == x.wb, (x.cause != 0) ? "R9" : "R8", "respWriteBack",
          64'(respWriteBack), 64'(x.wb));
    check(respEntry[11:9] == x.inEntry[11:9] && respEntry[63:7] == x.inEntry[63:7],
          "R10", "pass-through bits", respEntry, x.inEntry);
  endtask

  task automatic step(bit v, logic [63:0] e, int k, int p);
    @(negedge clk);
    compare();
    reqValid = v;
    reqEntry = e;
    reqKind  = 2'(k);
    reqPriv  = 2'(p);
    pending.push_back(model(v, e, k, p));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [63:0] base;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(respValid == 0 && respWriteBack == 0 && respFault == 0 && respEntry == 0,
          "R1", "reset outputs", respEntry, 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: first clock after release with no request
    check(respValid == 0 && respWriteBack == 0 && respFault == 0 && respEntry == 0,
          "R1", "post-reset outputs", respEntry, 64'd0);

    base = 64'h0000_0000_0000_0007; // present, writable, user
    // R7/R8 first access and repeats
    step(1, base, 0, 0);
    step(1, base | 64'h20, 0, 3);
    step(1, base | 64'h20, 1, 0);
    step(1, base | 64'h60, 1, 3);
    step(1, base, 2, 0);
    step(1, base, 1, 1);
    step(0, base, 1, 1);
    // R3 absent outranks all
    step(1, 64'h8000_0000_0000_0000, 2, 3);
    step(1, 64'h0000_0000_0000_0E06, 1, 0);
    // R4 privilege
    step(1, 64'h0000_0000_0000_0003, 0, 3);
    step(1, 64'h8000_0000_0000_0001, 1, 3);
    step(1, 64'h0000_0000_0000_0003, 0, 2);
    // R5 read-only
    step(1, 64'h0000_0000_0000_0005, 1, 3);
    step(1, 64'h0000_0000_0000_0005, 0, 3);
    step(1, 64'h0000_0000_0000_0005, 3, 0);
    // R6 no-execute
    step(1, 64'h8000_0000_0000_0007, 2, 3);
    step(1, 64'h8000_0000_0000_0007, 0, 3);
    step(1, 64'h8000_0000_0000_0007, 1, 0);
    // R10 software bits with various values
    for (int i = 0; i < 8; i++) step(1, base | (64'(i) << 9) | 64'hABCD_0000_0000_0000, i % 3, 0);
    step(0, '0, 0, 0);
    // random sweep
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) != 0, {$urandom, $urandom}, $urandom % 4, $urandom % 4);
    end
    step(0, '0, 0, 0);
    @(negedge clk);
    compare();
    finish_run();
  end
endmodule